// File: doc/BRIEF.md
# Programmable Serial Test-Pattern Generator

This block turns a configured seed into a serial bit stream for link and channel testing. In one mode it runs a linear feedback shift register whose length (1 to 32 stages) and second feedback position are set at run time, which produces a pseudorandom sequence. In the other mode it rotates the low bits of the seed, so a word of 1 to 32 bits repeats on the line. The configuration is presented as plain inputs (mode, length, tap, seed, error rate, invert), and a rising edge on the load input copies it into the shift engine.

A gate input lets the stream follow a gapped or fractional channel clock. While the gate is low, nothing advances. For testing a receiver's error counting, the output can be corrupted on purpose. A rate code flips one bit in every 10^n transmitted bits, and a rising edge on a request input flips exactly one bit. A final invert control complements the whole stream.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `tx_data` is 0 (with `cfg_invert` low), the engine is filled with ones, and the error counter and pending single error are cleared.
- R2: With `cfg_word_mode` = 0, length N = `cfg_len`+1 and tap t = `cfg_tap` (t < N-1), the bits after a load are seed bits N-1 down to 0 and then follow b[k+N] = b[k] XOR b[k+N-1-t]. A tap of N-1 or above contributes 0.
- R3: With `cfg_word_mode` = 1, the stream repeats the low N bits of the seed, bit N-1 first, with period N, for any N from 1 to 32.
- R4: A rising edge of `load` that is sampled at clock edge k reloads the engine at edge k and leaves `tx_data` unchanged there. The first new bit is on `tx_data` after edge k+1 when `tx_gate` is high. Holding `load` high does not reload again.
- R5: In pseudorandom mode, a seed whose low N bits are all zero is loaded as all ones, so the stream is never stuck at zero.
- R6: At an edge where `tx_gate` is low and there is no reload, the engine, `tx_data` and the error-interval counter keep their values.
- R7: `cfg_invert` = 1 complements `tx_data` combinationally, without affecting the engine.
- R8: For `cfg_err_rate` = n in 1..7, the produced bit with index i (counted from 0 after the last load, over non-gapped edges only) is flipped when (i+1) is a multiple of 10^n. Code 0 inserts no errors.
- R9: A rising edge of `err_single` flips exactly one bit. That is the bit produced at the same edge when the gate is high, otherwise the next non-gapped bit. If it falls on a bit that the rate also flips, that bit is flipped once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_gate | input | 1 | High lets the stream advance; low holds it |
| load | input | 1 | Rising edge reloads the engine from the configuration |
| cfg_word_mode | input | 1 | 0 pseudorandom, 1 repeating word |
| cfg_len | input | 5 | Pattern length minus one |
| cfg_tap | input | 5 | Second feedback stage index |
| cfg_seed | input | 32 | Seed or repeating word |
| cfg_err_rate | input | 3 | Error rate code, one error per 10^n bits, 0 off |
| err_single | input | 1 | Rising edge inserts one error |
| cfg_invert | input | 1 | Complements the output |
| tx_data | output | 1 | Serial output |

## Verification
The pseudorandom mode is driven with three different length and tap pairs, including the full 32-stage case. These runs separate the wrong stage taken as the head, a wrong tap index and a wrong shift direction. Repeating words of length 1, 5, 8 and 32 catch errors in length masking and period. All-zero words isolate the inserted errors, so their exact count per window shows off-by-one in the interval, and a stream that is still zero after a zero pseudorandom seed shows a missing lock-up guard. Irregular gate patterns, with loads and error requests landing inside gaps, show whether state, the interval counter and a pending error are held across gaps.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    localparam int PPG_W  = 32;
    localparam int LEN_W  = $clog2(PPG_W);
    localparam int RATE_W = 3;
    localparam int CNT_W  = 24;

    typedef enum logic {
        MODE_PRBS = 1'b0,
        MODE_WORD = 1'b1
    } ppg_mode_e;

    typedef struct packed {
        ppg_mode_e          mode;
        logic [LEN_W-1:0]   len;
        logic [LEN_W-1:0]   tap;
        logic [PPG_W-1:0]   seed;
    } ppg_cfg_t;

    function automatic logic [PPG_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [PPG_W-1:0] m;
        for (int i = 0; i < PPG_W; i++) begin
            m[i] = (i <= int'(len));
        end
        return m;
    endfunction

    function automatic logic [CNT_W-1:0] rate_limit(input logic [RATE_W-1:0] code);
        logic [CNT_W-1:0] v;
        v = CNT_W'(1);
        for (int i = 1; i < (1 << RATE_W); i++) begin
            if (i <= int'(code)) begin
                v = v * CNT_W'(10);
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/ppg_rise_det.sv
module ppg_rise_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= din;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise[g] = din[g] & ~prev_q[g];
    end
endmodule

// File: rtl/ppg_shift_engine.sv
module ppg_shift_engine
    import ppg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     reload,
    input  logic     advance,
    input  ppg_cfg_t cfg,
    output logic     head_bit
);
    logic [PPG_W-1:0] state_q, state_d, mask, seed_m;
    logic             tap_bit, fb;

    always_comb begin
        mask     = len_mask(cfg.len);
        seed_m   = cfg.seed & mask;
        head_bit = state_q[cfg.len];
        tap_bit  = (cfg.tap < cfg.len) ? state_q[cfg.tap] : 1'b0;
        fb       = (cfg.mode == MODE_WORD) ? head_bit : (head_bit ^ tap_bit);
        state_d  = state_q;
        if (reload) begin
            state_d = ((cfg.mode == MODE_PRBS) && (seed_m == '0)) ? mask : seed_m;
        end else if (advance) begin
            state_d = {state_q[PPG_W-2:0], fb} & mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '1;
        else     state_q <= state_d;
    end

    // R5
    zero_seed_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (reload && cfg.mode == MODE_PRBS) |=> ((state_q & $past(mask)) != '0));

    // R6
    engine_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!advance && !reload) |=> (state_q == $past(state_q)));
endmodule

// File: rtl/ppg_error_unit.sv
module ppg_error_unit
    import ppg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reload,
    input  logic              advance,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              single_rise,
    output logic              flip
);
    logic [CNT_W-1:0] cnt_q, lim;
    logic             pend_q, rate_hit;

    always_comb begin
        lim      = rate_limit(rate_code);
        rate_hit = (rate_code != '0) && (cnt_q >= lim - CNT_W'(1));
        flip     = advance && (rate_hit || pend_q || single_rise);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (reload) begin
                cnt_q <= '0;
            end else if (advance) begin
                cnt_q <= (rate_code == '0 || rate_hit) ? '0 : cnt_q + CNT_W'(1);
            end
            if (advance)          pend_q <= 1'b0;
            else if (single_rise) pend_q <= 1'b1;
        end
    end

    // R8
    interval_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && rate_hit) |=> (cnt_q == '0));

    // R9
    single_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (single_rise && !advance) |=> pend_q);

    // R6
    interval_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!advance && !reload) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
    import ppg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_gate,
    input  logic              load,
    input  logic              cfg_word_mode,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [LEN_W-1:0]  cfg_tap,
    input  logic [PPG_W-1:0]  cfg_seed,
    input  logic [RATE_W-1:0] cfg_err_rate,
    input  logic              err_single,
    input  logic              cfg_invert,
    output logic              tx_data
);
    ppg_cfg_t cfg;
    logic [1:0] rise;
    logic       reload, advance, head_bit, flip, out_q;

    always_comb begin
        cfg.mode = cfg_word_mode ? MODE_WORD : MODE_PRBS;
        cfg.len  = cfg_len;
        cfg.tap  = cfg_tap;
        cfg.seed = cfg_seed;
    end

    ppg_rise_det #(.N(2)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .din  ({err_single, load}),
        .rise (rise)
    );

    assign reload  = rise[0];
    assign advance = tx_gate && !reload;

    ppg_shift_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .reload   (reload),
        .advance  (advance),
        .cfg      (cfg),
        .head_bit (head_bit)
    );

    ppg_error_unit u_err (
        .clk         (clk),
        .rst         (rst),
        .reload      (reload),
        .advance     (advance),
        .rate_code   (cfg_err_rate),
        .single_rise (rise[1]),
        .flip        (flip)
    );

    always_ff @(posedge clk) begin
        if (rst)          out_q <= 1'b0;
        else if (advance) out_q <= head_bit ^ flip;
    end

    assign tx_data = out_q ^ cfg_invert;

    // R4
    reload_latency_chk: assert property (@(posedge clk) disable iff (rst)
        reload |=> (out_q == $past(out_q)));

    // R6
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_gate && !reload) |=> (out_q == $past(out_q)));

    // R7
    invert_path_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_invert == $past(cfg_invert) && !$past(advance)) |-> $stable(tx_data));
endmodule

// File: tb/prbs_pattern_gen_test.sv
`timescale 1ns/1ps
module prbs_pattern_gen_test;
    localparam time CYC = 8ns;

    logic        clk = 0, rst = 1, tx_gate = 1, load = 0, cfg_word_mode = 0;
    logic [4:0]  cfg_len = 5'd6, cfg_tap = 5'd5;
    logic [31:0] cfg_seed = 32'h0;
    logic [2:0]  cfg_err_rate = 3'd0;
    logic        err_single = 0, cfg_invert = 0;
    logic        tx_data;

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    prbs_pattern_gen uut (
        .clk(clk), .rst(rst), .tx_gate(tx_gate), .load(load),
        .cfg_word_mode(cfg_word_mode), .cfg_len(cfg_len), .cfg_tap(cfg_tap),
        .cfg_seed(cfg_seed), .cfg_err_rate(cfg_err_rate), .err_single(err_single),
        .cfg_invert(cfg_invert), .tx_data(tx_data)
    );

    always #(CYC/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit q[$];
    int m_n = 7, m_t = 5, cnt = 0;
    bit m_word = 0, pend = 0, ld_prev = 0, se_prev = 0, exp_out = 0;

    function automatic int lim_of(input int c);
        int v = 1;
        for (int i = 0; i < c; i++) v = v * 10;
        return v;
    endfunction

    always @(posedge clk) begin
        bit lr, sr, b, nb, fl, hit;
        logic [31:0] sd;
        if (rst) begin
            q.delete();
            m_n = int'(cfg_len) + 1; m_t = int'(cfg_tap); m_word = cfg_word_mode;
            for (int i = 0; i < m_n; i++) q.push_back(1'b1);
            exp_out = 0; cnt = 0; pend = 0; ld_prev = 0; se_prev = 0;
        end else begin
            lr = load && !ld_prev;
            sr = err_single && !se_prev;
            ld_prev = load; se_prev = err_single;
            if (lr) begin
                m_n = int'(cfg_len) + 1; m_t = int'(cfg_tap); m_word = cfg_word_mode;
                sd = cfg_seed;
                q.delete();
                for (int i = m_n - 1; i >= 0; i--) q.push_back(sd[i]);
                if (!m_word && !(1'b1 inside {q})) begin
                    foreach (q[i]) q[i] = 1'b1;
                end
                cnt = 0;
                pend = pend | sr;
            end else if (tx_gate) begin
                b = q[0];
                if (m_word) nb = b;
                else nb = b ^ ((m_t < m_n - 1) ? q[m_n - 1 - m_t] : 1'b0);
                void'(q.pop_front());
                q.push_back(nb);
                hit = (cfg_err_rate != 0) && (cnt == lim_of(int'(cfg_err_rate)) - 1);
                fl = sr || pend || hit;
                if (cfg_err_rate == 0 || hit) cnt = 0; else cnt++;
                pend = 0;
                exp_out = b ^ fl;
            end else begin
                pend = pend | sr;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) chk(cur_req, {31'd0, tx_data}, {31'd0, exp_out ^ cfg_invert});
    end

    // ---------------- stimulus ----------------
    task automatic run(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_load();
        load = 1; run(1); load = 0;
    endtask

    task automatic count_ones(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            c += int'(tx_data);
        end
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CYC * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int c;
        // R1 reset state
        run(2);
        chk("R1", {31'd0, tx_data}, 32'd0);
        run(1);
        chk("R1", {31'd0, tx_data}, 32'd0);
        rst = 0;
        run(20);

        // R2 pseudorandom, three lengths
        cur_req = "R2";
        cfg_word_mode = 0; cfg_len = 6; cfg_tap = 5; cfg_seed = 32'h5A; do_load(); run(260);
        cfg_len = 31; cfg_tap = 21; cfg_seed = 32'hDEADBEEF; do_load(); run(200);
        cfg_len = 14; cfg_tap = 13; cfg_seed = 32'h1234; do_load(); run(120);

        // R3 repeating words
        cur_req = "R3";
        cfg_word_mode = 1; cfg_len = 7; cfg_seed = 32'hA5; do_load(); run(40);
        cfg_len = 0; cfg_seed = 32'h1; do_load(); run(10);
        cfg_len = 31; cfg_seed = 32'h12345678; do_load(); run(80);
        cfg_len = 4; cfg_seed = 32'h13; do_load(); run(30);

        // R4 load latency, load held high
        cur_req = "R4";
        cfg_len = 3; cfg_seed = 32'h0; do_load(); run(8);
        cfg_len = 7; cfg_seed = 32'h80; load = 1;
        @(negedge clk); chk("R4", {31'd0, tx_data}, 32'd0);
        @(negedge clk); chk("R4", {31'd0, tx_data}, 32'd1);
        @(negedge clk); chk("R4", {31'd0, tx_data}, 32'd0);
        #1; run(10);
        load = 0; run(5);

        // R5 zero seed lock-up guard
        cur_req = "R5";
        cfg_word_mode = 0; cfg_len = 4; cfg_tap = 2; cfg_seed = 32'h0; do_load();
        count_ones(30, c);
        chk("R5", c, (c > 0) ? c : 32'd1);

        // R6 gapped clocking with loads and requests in gaps
        cur_req = "R6";
        cfg_len = 6; cfg_tap = 5; cfg_seed = 32'h33; cfg_err_rate = 3'd1; do_load();
        for (int i = 0; i < 90; i++) begin
            tx_gate = (i % 3 != 0);
            err_single = (i == 40);
            if (i == 61) begin cfg_seed = 32'h21; load = 1; end
            if (i == 63) load = 0;
            run(1);
        end
        tx_gate = 0; run(6);
        tx_gate = 1; err_single = 0; run(20);

        // R7 invert
        cur_req = "R7";
        cfg_err_rate = 0; do_load();
        for (int i = 0; i < 40; i++) begin
            cfg_invert = (i % 7 < 3);
            run(1);
        end
        cfg_invert = 0; run(3);

        // R8 rate-coded insertion on an all-zero word
        cur_req = "R8";
        cfg_word_mode = 1; cfg_len = 7; cfg_seed = 32'h0;
        cfg_err_rate = 3'd1; do_load(); count_ones(100, c); chk("R8", c, 32'd10);
        cfg_err_rate = 3'd2; do_load(); count_ones(300, c); chk("R8", c, 32'd3);
        cfg_err_rate = 3'd0; do_load(); count_ones(100, c); chk("R8", c, 32'd0);

        // R9 single error
        cur_req = "R9";
        err_single = 1; count_ones(20, c); chk("R9", c, 32'd1);
        err_single = 0; run(2);
        tx_gate = 0; err_single = 1; run(3); err_single = 0; run(2);
        tx_gate = 1; count_ones(20, c); chk("R9", c, 32'd1);
        cfg_err_rate = 3'd1; do_load(); run(8);
        err_single = 1; run(1); err_single = 0; run(30);
        cfg_word_mode = 0; cfg_len = 6; cfg_tap = 5; cfg_seed = 32'h5A; do_load(); run(40);

        finish_run();
    end
endmodule